// File: doc/BRIEF.md
# UART Prioritized Interrupt Identification Unit

This unit gathers the interrupt conditions of a single serial channel and reduces them to one identification byte, together with an interrupt request line. Seven sources are tracked: line error, receive data available, receive timeout, transmit holding register empty, modem line change, flow-control stop character (or special character) seen, and hardware flow line change. Each source holds a sticky pending flag. The flag is set by a one-cycle pulse from the logic that detects the condition.

Software reads the identification byte to find the most urgent pending source. The byte is frozen while the read strobe is high. When the strobe falls, the reported source is cleared if it is one of the sources that a read clears. The other sources stay pending until their own condition-clear pulse arrives. The stop-character source is cleared only by a resume-character pulse. The two highest bit-position sources report only when the enhanced-features enable is set.

Top module: `uart_irq_ident`

## Requirements
- R1: After a synchronous active-low reset, every pending flag is clear, `iir_o[5:0]` is 0x01 and `irq_o` is 0.
- R2: When one source is pending, `iir_o[5:0]` carries its code: line error (index 0) 0x06, receive data (1) 0x04, receive timeout (2) 0x0C, transmit empty (3) 0x02, modem (4) 0x00, stop character (5) 0x10, flow line change (6) 0x20.
- R3: When several enabled sources are pending, the one with the lowest index is reported.
- R4: `iir_o[7:6]` reads 2'b11 when `fifo_en_i` is 1 and 2'b00 when it is 0.
- R5: `iir_o[0]` is 0 exactly when an enabled source is pending. Outside a read, `irq_o` is the inverse of `iir_o[0]`.
- R6: A source whose `irq_en_i` bit is 0 is not reported, but it stays pending and appears once it is enabled.
- R7: When `enh_en_i` is 0, sources 5 and 6 are not reported and `iir_o[5:4]` is 00.
- R8: When the read strobe falls, the reported source is cleared if it is source 3 or source 6. The next pending source then appears.
- R9: A read does not clear sources 0, 1, 2, 4 or 5. Each of these is cleared by its own `cond_clr_i` bit. The `cond_clr_i` bits 3 and 6 have no effect.
- R10: Once source 5 is pending, it stays pending through reads until `cond_clr_i[5]` (the resume-character pulse) arrives.
- R11: `iir_o` keeps the value it had on the first cycle of the read strobe until the strobe falls. A source that arrives during the read is held pending and reported afterwards.
- R12: A set pulse arriving in the same cycle as any clear of that source leaves the source pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| set_i | input | 7 | Per-source set pulse, index as in R2 |
| cond_clr_i | input | 7 | Per-source condition-clear pulse (bit 5 = resume character seen) |
| irq_en_i | input | 7 | Per-source enable |
| enh_en_i | input | 1 | Enhanced-features enable for sources 5 and 6 |
| fifo_en_i | input | 1 | FIFO mode flag reflected in bits 7:6 |
| rd_i | input | 1 | Identification register read strobe, high for one or more cycles |
| iir_o | output | 8 | Interrupt identification byte |
| irq_o | output | 1 | Interrupt request, high while an enabled source is pending |

## Verification
The assertions run on every cycle. They check the relation between `irq_o` and bit 0, the FIFO bits, the hiding of the enhanced sources, that the reported code is always legal, that the byte holds still during a read, the reset value, and that the stop-character flag survives without a resume pulse. The bench scenarios are needed to show behaviour that depends on history: the exact code of each source, the priority order, which sources a read clears and which it leaves, masked sources reappearing once enabled, a source arriving during a read being reported afterwards, and set winning over a clear in the same cycle.

// File: rtl/uart_irq_pkg.sv
// Package: source indices, codes and clear-behaviour masks shared by
// the interrupt identification unit. Assumes seven sources, index 0 highest.
package uart_irq_pkg;

    localparam int NSRC = 7;
    localparam int IDXW = $clog2(NSRC);

    typedef enum logic [IDXW-1:0] {
        SRC_LINE  = 3'd0,
        SRC_RXRDY = 3'd1,
        SRC_RXTMO = 3'd2,
        SRC_THRE  = 3'd3,
        SRC_MODEM = 3'd4,
        SRC_XOFF  = 3'd5,
        SRC_FLOW  = 3'd6
    } src_e;

    // Sources that the trailing edge of a read clears.
    localparam logic [NSRC-1:0] RDCLR_MASK = 7'b100_1000;
    // Sources that report only with the enhanced-features enable.
    localparam logic [NSRC-1:0] ENH_MASK   = 7'b110_0000;

    // Six low bits of the identification byte for a pending source.
    function automatic logic [5:0] src_code(input logic [IDXW-1:0] idx);
        logic [5:0] c;
        case (idx)
            SRC_LINE:  c = 6'h06;
            SRC_RXRDY: c = 6'h04;
            SRC_RXTMO: c = 6'h0C;
            SRC_THRE:  c = 6'h02;
            SRC_MODEM: c = 6'h00;
            SRC_XOFF:  c = 6'h10;
            SRC_FLOW:  c = 6'h20;
            default:   c = 6'h01;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/uart_irq_pending.sv
// Sticky pending flags, one per source. A set pulse wins over any clear.
// A source is cleared by its condition pulse or by the read clear,
// depending on which mask it belongs to. Assumes pulses last one cycle.
module uart_irq_pending #(
    parameter int N = 7,
    parameter logic [N-1:0] RD_MASK = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] cond_clr_i,
    input  logic [N-1:0] rd_clr_i,
    output logic [N-1:0] pend_o
);

    logic [N-1:0] clr_w;

    // Pick the clear path of each source by its mask bit.
    assign clr_w = (cond_clr_i & ~RD_MASK) | (rd_clr_i & RD_MASK);

    for (genvar i = 0; i < N; i++) begin : g_flag
        // Hold one pending flag; set has priority over clear.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pend_o[i] <= 1'b0;
            end else if (set_i[i]) begin
                pend_o[i] <= 1'b1;
            end else if (clr_w[i]) begin
                pend_o[i] <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/uart_irq_prio.sv
// Masks the pending flags with the per-source enables and the enhanced
// enable, then picks the lowest-index survivor. Purely combinational.
module uart_irq_prio #(
    parameter int N  = 7,
    parameter int IW = 3,
    parameter logic [N-1:0] ENH = '0
) (
    input  logic [N-1:0]  pend_i,
    input  logic [N-1:0]  en_i,
    input  logic          enh_en_i,
    output logic          any_o,
    output logic [IW-1:0] idx_o
);

    logic [N-1:0] eff_w;

    // Effective requests after both masks.
    assign eff_w = pend_i & en_i & ~(ENH & {N{~enh_en_i}});

    // Scan from lowest priority up so the lowest index is kept last.
    always_comb begin
        any_o = 1'b0;
        idx_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (eff_w[i]) begin
                any_o = 1'b1;
                idx_o = IW'(i);
            end
        end
    end

endmodule

// File: rtl/uart_irq_rdlatch.sv
// Read handling: freezes the identification byte from the first strobe
// cycle and, on the strobe's falling edge, issues a one-hot clear for
// the source it reported. Assumes rd_i is synchronous to clk.
module uart_irq_rdlatch #(
    parameter int N  = 7,
    parameter int IW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_i,
    input  logic [7:0]    live_i,
    input  logic          live_any_i,
    input  logic [IW-1:0] live_idx_i,
    output logic [7:0]    iir_o,
    output logic [N-1:0]  rd_clr_o
);

    logic          rd_q;
    logic [7:0]    held_iir;
    logic          held_any;
    logic [IW-1:0] held_idx;
    logic          rise_w;
    logic          fall_w;

    assign rise_w = rd_i & ~rd_q;
    assign fall_w = ~rd_i & rd_q;

    // Track the strobe and capture the reported value on its first cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q     <= 1'b0;
            held_iir <= 8'h01;
            held_any <= 1'b0;
            held_idx <= '0;
        end else begin
            rd_q <= rd_i;
            if (rise_w) begin
                held_iir <= live_i;
                held_any <= live_any_i;
                held_idx <= live_idx_i;
            end
        end
    end

    // Show the frozen byte after the first strobe cycle.
    assign iir_o = (rd_i && rd_q) ? held_iir : live_i;

    for (genvar i = 0; i < N; i++) begin : g_clr
        // One-hot clear for the reported source at the trailing edge.
        assign rd_clr_o[i] = fall_w && held_any && (held_idx == IW'(i));
    end

endmodule

// File: rtl/uart_irq_ident.sv
// Top of the interrupt identification unit: pending flags, priority
// pick, byte assembly and read freeze/clear. All inputs are synchronous
// to clk; set and clear inputs are single-cycle pulses.
module uart_irq_ident
    import uart_irq_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] set_i,
    input  logic [NSRC-1:0] cond_clr_i,
    input  logic [NSRC-1:0] irq_en_i,
    input  logic            enh_en_i,
    input  logic            fifo_en_i,
    input  logic            rd_i,
    output logic [7:0]      iir_o,
    output logic            irq_o
);

    logic [NSRC-1:0] pend_w;
    logic [NSRC-1:0] rd_clr_w;
    logic            any_w;
    logic [IDXW-1:0] idx_w;
    logic [7:0]      live_w;

    uart_irq_pending #(.N(NSRC), .RD_MASK(RDCLR_MASK)) u_pend (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_i      (set_i),
        .cond_clr_i (cond_clr_i),
        .rd_clr_i   (rd_clr_w),
        .pend_o     (pend_w)
    );

    uart_irq_prio #(.N(NSRC), .IW(IDXW), .ENH(ENH_MASK)) u_prio (
        .pend_i   (pend_w),
        .en_i     (irq_en_i),
        .enh_en_i (enh_en_i),
        .any_o    (any_w),
        .idx_o    (idx_w)
    );

    // Build the live identification byte from mode bits and the winner.
    assign live_w = {{2{fifo_en_i}}, (any_w ? src_code(idx_w) : 6'h01)};

    uart_irq_rdlatch #(.N(NSRC), .IW(IDXW)) u_rd (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_i       (rd_i),
        .live_i     (live_w),
        .live_any_i (any_w),
        .live_idx_i (idx_w),
        .iir_o      (iir_o),
        .rd_clr_o   (rd_clr_w)
    );

    // Request line follows the live pending state.
    assign irq_o = any_w;

endmodule

// File: rtl/uart_irq_ident_chk.sv
// Checker for uart_irq_ident, attached by bind. Observes ports and the
// pending flags; drives nothing.
module uart_irq_ident_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       rd_i,
    input logic       enh_en_i,
    input logic       fifo_en_i,
    input logic [6:0] cond_clr_i,
    input logic [6:0] pend,
    input logic [7:0] iir_o,
    input logic       irq_o
);

    // R1: reset leaves the idle code and no request.
    a_r1_reset_idle: assert property (@(posedge clk)
        !rst_n |=> (iir_o[5:0] == 6'h01 && !irq_o));

    // R5: request line mirrors bit 0 outside reads.
    a_r5_irq_bit0: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_i |-> (irq_o == !iir_o[0]));

    // R4: mode bits follow the FIFO flag outside reads.
    a_r4_fifo_bits: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_i |-> (iir_o[7:6] == {2{fifo_en_i}}));

    // R7: enhanced sources hidden without the enable.
    a_r7_enh_hidden: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_i && !enh_en_i) |-> (iir_o[5:4] == 2'b00));

    // R2: only legal codes ever appear.
    a_r2_legal_code: assert property (@(posedge clk) disable iff (!rst_n)
        iir_o[5:0] inside {6'h01, 6'h06, 6'h04, 6'h0C, 6'h02, 6'h00, 6'h10, 6'h20});

    // R11: byte frozen while the strobe stays high.
    a_r11_read_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && $past(rd_i)) |-> $stable(iir_o));

    // R10: stop-character flag survives without a resume pulse.
    a_r10_xoff_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (pend[5] && !cond_clr_i[5]) |=> pend[5]);

endmodule

bind uart_irq_ident uart_irq_ident_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_i       (rd_i),
    .enh_en_i   (enh_en_i),
    .fifo_en_i  (fifo_en_i),
    .cond_clr_i (cond_clr_i),
    .pend       (pend_w),
    .iir_o      (iir_o),
    .irq_o      (irq_o)
);

// File: tb/tb_uart_irq_ident.sv
// Directed bench for uart_irq_ident: inputs change and outputs are
// sampled on the falling clock edge.
module tb_uart_irq_ident;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [6:0] set_i = '0;
    logic [6:0] cond_clr_i = '0;
    logic [6:0] irq_en_i = 7'h7F;
    logic       enh_en_i = 1'b1;
    logic       fifo_en_i = 1'b0;
    logic       rd_i = 1'b0;
    logic [7:0] iir_o;
    logic       irq_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    uart_irq_ident dut (
        .clk(clk), .rst_n(rst_n), .set_i(set_i), .cond_clr_i(cond_clr_i),
        .irq_en_i(irq_en_i), .enh_en_i(enh_en_i), .fifo_en_i(fifo_en_i),
        .rd_i(rd_i), .iir_o(iir_o), .irq_o(irq_o)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic pulse_set(input int i);
        set_i[i] = 1'b1;
        @(negedge clk);
        set_i = '0;
    endtask

    task automatic pulse_clr(input int i);
        cond_clr_i[i] = 1'b1;
        @(negedge clk);
        cond_clr_i = '0;
    endtask

    // Two-cycle read; returns the frozen value.
    task automatic do_read(output logic [7:0] v);
        rd_i = 1'b1;
        @(negedge clk);
        v = iir_o;
        @(negedge clk);
        rd_i = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1 iir", iir_o, 8'h01);
        chk("R1 irq", {7'd0, irq_o}, 8'h00);
    endtask

    task automatic t_codes();
        logic [7:0] codes [7] = '{8'h06, 8'h04, 8'h0C, 8'h02, 8'h00, 8'h10, 8'h20};
        logic [7:0] v;
        for (int i = 0; i < 7; i++) begin
            pulse_set(i);
            chk($sformatf("R2 code src%0d", i), iir_o, codes[i]);
            chk("R5 irq high", {7'd0, irq_o}, 8'h01);
            if (i == 3 || i == 6) do_read(v); else pulse_clr(i);
            chk("R5 idle after clear", iir_o, 8'h01);
        end
    endtask

    task automatic t_fifo();
        fifo_en_i = 1'b1;
        pulse_set(0);
        chk("R4 fifo bits pending", iir_o, 8'hC6);
        pulse_clr(0);
        chk("R4 fifo bits idle", iir_o, 8'hC1);
        fifo_en_i = 1'b0;
        @(negedge clk);
        chk("R4 fifo off", iir_o, 8'h01);
    endtask

    task automatic t_prio();
        logic [7:0] v;
        set_i = 7'h7F;
        @(negedge clk);
        set_i = '0;
        chk("R3 top line", iir_o, 8'h06);
        do_read(v);
        chk("R3 read value", v, 8'h06);
        chk("R9 line kept by read", iir_o, 8'h06);
        pulse_clr(0);
        chk("R3 rx next", iir_o, 8'h04);
        pulse_clr(1);
        chk("R3 tmo next", iir_o, 8'h0C);
        pulse_clr(2);
        chk("R3 thre next", iir_o, 8'h02);
        do_read(v);
        chk("R8 thre read value", v, 8'h02);
        chk("R8 thre cleared, modem next", iir_o, 8'h00);
        pulse_clr(4);
        chk("R3 xoff next", iir_o, 8'h10);
        do_read(v);
        chk("R10 xoff kept by read", iir_o, 8'h10);
        pulse_clr(5);
        chk("R10 xon clears, flow next", iir_o, 8'h20);
        do_read(v);
        chk("R8 flow cleared", iir_o, 8'h01);
    endtask

    task automatic t_mask();
        irq_en_i = 7'h7E;
        pulse_set(0);
        chk("R6 masked hidden", iir_o, 8'h01);
        chk("R6 masked no irq", {7'd0, irq_o}, 8'h00);
        irq_en_i = 7'h7F;
        @(negedge clk);
        chk("R6 kept pending", iir_o, 8'h06);
        pulse_clr(0);
    endtask

    task automatic t_enh();
        logic [7:0] v;
        enh_en_i = 1'b0;
        pulse_set(6);
        chk("R7 flow hidden", iir_o, 8'h01);
        enh_en_i = 1'b1;
        @(negedge clk);
        chk("R7 flow shown", iir_o, 8'h20);
        do_read(v);
        chk("R8 flow cleared by read", iir_o, 8'h01);
    endtask

    task automatic t_ignore();
        logic [7:0] v;
        pulse_set(3);
        pulse_clr(3);
        chk("R9 cond clr ignored for thre", iir_o, 8'h02);
        pulse_set(6);
        pulse_clr(6);
        pulse_set(0);
        do_read(v);
        chk("R9 line survives read", iir_o, 8'h06);
        pulse_clr(0);
        do_read(v);
        do_read(v);
        chk("R9 flow survived cond clr then read", v, 8'h20);
        chk("R9 all clear", iir_o, 8'h01);
    endtask

    task automatic t_midread();
        pulse_set(3);
        rd_i = 1'b1;
        @(negedge clk);
        set_i[0] = 1'b1;
        @(negedge clk);
        set_i = '0;
        chk("R11 held during read", iir_o, 8'h02);
        rd_i = 1'b0;
        @(negedge clk);
        chk("R11 new source after read", iir_o, 8'h06);
        pulse_clr(0);
        chk("R8 held thre cleared", iir_o, 8'h01);
    endtask

    task automatic t_setwins();
        pulse_set(3);
        rd_i = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rd_i = 1'b0;
        set_i[3] = 1'b1;
        @(negedge clk);
        set_i = '0;
        chk("R12 set beats read clear", iir_o, 8'h02);
        set_i[0] = 1'b1;
        cond_clr_i[0] = 1'b1;
        @(negedge clk);
        set_i = '0;
        cond_clr_i = '0;
        chk("R12 set beats cond clear", iir_o, 8'h06);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_codes();
        t_fifo();
        t_prio();
        t_mask();
        t_enh();
        t_ignore();
        t_midread();
        t_setwins();
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset clears sticky", iir_o, 8'h01);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule